// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a four-mode processor with a 26-bit byte address space. It holds 26 general 32-bit registers plus a combined program-counter/status word, which gives 27 physical registers. Sixteen of them are visible at any moment. The current processor mode, supplied on every cycle, decides which physical copy each of the architectural numbers 0 to 14 refers to.

Register 15 is assembled on read from four parts: the stored flags, the two interrupt-disable bits, the 24-bit word-aligned program counter, and the current mode. Writes to register 15 are split back into those fields. The program counter and the flags also have dedicated update paths, so that the fetch and ALU logic can change them without going through the write port. A link-capture input copies the whole register-15 word into the R14 of a chosen mode. This serves branch-with-link and exception entry.

Top module: `banked_regfile`

## Requirements
- R1: The mode code is 2 bits: 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor. In fast-interrupt mode (01), architectural registers 8 to 14 reach seven private registers, and the user copies are left untouched.
- R2: In interrupt mode (10) and supervisor mode (11), only registers 13 and 14 are private, with one pair per mode. Registers 0 to 12 are the user copies.
- R3: In fast-interrupt mode, registers 0 to 7 are shared with user mode.
- R4: A read of register 15 returns {N,Z,C,V, irq_disable, fiq_disable, PC[23:0], mode}. Here N sits in bit 31, irq_disable in bit 27, fiq_disable in bit 26, the PC in bits 25:2, and the current mode input in bits 1:0.
- R5: `fetch_addr` is the 24-bit PC followed by two zero bits.
- R6: A port write to register 15 in a non-user mode loads the flags from bits 31:28, the disable bits from bits 27:26 and the PC from bits 25:2. Data bits 1:0 are ignored.
- R7: A port write to register 15 in user mode loads only the PC and the flags. Both disable bits keep their values.
- R8: `pc_we` loads the PC from `pc_next` and `flags_we` loads the flags from `flags_next`. Each takes precedence over a same-cycle port write to register 15 for its own field only.
- R9: `link_we` stores the register-15 word as it reads before the edge into the R14 of the bank that `link_mode` selects. Its bits 1:0 are the current mode. It takes precedence over a same-cycle port write to that same physical register.
- R10: Reads are combinational. A read in the same cycle as a write to the same register returns the old value, and the new value appears after the clock edge.
- R11: After reset, every general register reads zero, the PC is zero, the flags are zero, and both disable bits are 1.
- R12: Each access selects its bank from the mode input of the cycle in which it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Current processor mode |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 4 | Write port register number |
| wr_data | input | 32 | Write port data |
| pc_we | input | 1 | Dedicated PC update enable |
| pc_next | input | 24 | New word-aligned PC |
| flags_we | input | 1 | Dedicated flags update enable |
| flags_next | input | 4 | New N,Z,C,V |
| link_we | input | 1 | Capture register 15 into a mode's R14 |
| link_mode | input | 2 | Mode whose R14 receives the capture |
| fetch_addr | output | 26 | Instruction fetch byte address |

## Verification
The bench writes the same architectural number from different modes and reads it back from the other modes. A design that banks too many registers (R0 to R7 in fast-interrupt mode, or R8 to R12 in supervisor mode) or too few shows the wrong value in a mode that should share the register. Register-15 writes are checked from a user mode and from a privileged mode. A design that lets user code touch the disable bits, or that stores the mode bits from the data, returns a wrong composed word. Same-cycle conflicts are also covered: a dedicated PC path against a port write, a link capture against a port write to the same R14, and a read during a write. In each case a wrong priority or a bypassed read shows up as a value off by one write.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int XLEN = 32,
  parameter int PCW  = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic [3:0]      rd_a_addr,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_addr,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            pc_we,
  input  logic [PCW-1:0]  pc_next,
  input  logic            flags_we,
  input  logic [3:0]      flags_next,
  input  logic            link_we,
  input  logic [1:0]      link_mode,
  output logic [PCW+1:0]  fetch_addr
);
  localparam int NUSR  = 15;
  localparam int NFIQ  = 7;
  localparam int NPRIV = 2;
  localparam int NPHYS = NUSR + NFIQ + 2 * NPRIV;
  localparam int IW    = $clog2(NPHYS);
  localparam int FIQ_BASE = NUSR;
  localparam int SVC_BASE = FIQ_BASE + NFIQ;
  localparam int IRQ_BASE = SVC_BASE + NPRIV;
  localparam logic [1:0] M_USR = 2'b00, M_FIQ = 2'b01, M_IRQ = 2'b10, M_SVC = 2'b11;

  logic [XLEN-1:0] phys [NPHYS];
  logic [PCW-1:0]  pc_q;
  logic [3:0]      flg_q;
  logic            irqd_q, fiqd_q;
  logic [XLEN-1:0] r15_word;

  function automatic logic [IW-1:0] map_reg(input logic [1:0] m, input logic [3:0] a);
    logic [IW-1:0] ai;
    ai = IW'(a);
    if (m == M_FIQ && a >= 4'd8 && a <= 4'd14)
      return ai - IW'(8) + IW'(FIQ_BASE);
    if (m == M_SVC && a >= 4'd13 && a <= 4'd14)
      return ai - IW'(13) + IW'(SVC_BASE);
    if (m == M_IRQ && a >= 4'd13 && a <= 4'd14)
      return ai - IW'(13) + IW'(IRQ_BASE);
    return ai;
  endfunction

  assign r15_word   = {flg_q, irqd_q, fiqd_q, pc_q, mode_i};
  assign fetch_addr = {pc_q, 2'b00};
  assign rd_a_data  = (rd_a_addr == 4'd15) ? r15_word : phys[map_reg(mode_i, rd_a_addr)];
  assign rd_b_data  = (rd_b_addr == 4'd15) ? r15_word : phys[map_reg(mode_i, rd_b_addr)];

  logic          wr_gp, wr_pc15, priv;
  logic [IW-1:0] wr_idx, link_idx;
  assign wr_gp    = wr_en && (wr_addr != 4'd15);
  assign wr_pc15  = wr_en && (wr_addr == 4'd15);
  assign priv     = (mode_i != M_USR);
  assign wr_idx   = map_reg(mode_i, wr_addr);
  assign link_idx = map_reg(link_mode, 4'd14);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) phys[i] <= '0;
    end else begin
      if (wr_gp)   phys[wr_idx]   <= wr_data;
      if (link_we) phys[link_idx] <= r15_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      flg_q  <= '0;
      irqd_q <= 1'b1;
      fiqd_q <= 1'b1;
    end else begin
      if (pc_we)        pc_q <= pc_next;
      else if (wr_pc15) pc_q <= wr_data[PCW+1:2];
      if (flags_we)     flg_q <= flags_next;
      else if (wr_pc15) flg_q <= wr_data[XLEN-1:XLEN-4];
      if (wr_pc15 && priv) begin
        irqd_q <= wr_data[27];
        fiqd_q <= wr_data[26];
      end
    end
  end
endmodule

module banked_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_i,
  input logic [3:0]  rd_a_addr,
  input logic [31:0] rd_a_data,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        pc_we,
  input logic [23:0] pc_next,
  input logic        flags_we,
  input logic [3:0]  flags_next,
  input logic        link_we,
  input logic [25:0] fetch_addr,
  input logic [3:0]  flg_q,
  input logic        irqd_q,
  input logic        fiqd_q
);
  // R5
  pc_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> fetch_addr == {$past(pc_next), 2'b00});
  // R8
  flags_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |=> flg_q == $past(flags_next));
  // R7
  user_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd15 && mode_i == 2'b00) |=> $stable({irqd_q, fiqd_q}));
  // R6
  priv_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd15 && mode_i != 2'b00) |=> {irqd_q, fiqd_q} == $past(wr_data[27:26]));
  // R4
  r15_compose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == 4'd15) |-> rd_a_data[25:0] == {fetch_addr[25:2], mode_i});
  // R12
  same_bank_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && wr_addr != 4'd15 && !link_we) && rd_a_addr == $past(wr_addr)
      && mode_i == $past(mode_i)) |-> rd_a_data == $past(wr_data));
endmodule

bind banked_regfile banked_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pc_we(pc_we), .pc_next(pc_next),
  .flags_we(flags_we), .flags_next(flags_next), .link_we(link_we), .fetch_addr(fetch_addr),
  .flg_q(flg_q), .irqd_q(irqd_q), .fiqd_q(fiqd_q)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  mode_i = 0;
  logic [3:0]  rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0;
  logic        wr_en = 0, pc_we = 0, flags_we = 0, link_we = 0;
  logic [23:0] pc_next = 0;
  logic [3:0]  flags_next = 0;
  logic [1:0]  link_mode = 0;
  logic [25:0] fetch_addr;
  int n_run = 0, n_fail = 0;

  localparam logic [1:0] USR = 2'b00, FIQ = 2'b01, IRQ = 2'b10, SVC = 2'b11;

  always #2 clk = ~clk;

  banked_regfile u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    mode_i = m; wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [1:0] m, input logic [3:0] a, input logic [31:0] e);
    mode_i = m; rd_a_addr = a; rd_b_addr = a;
    #1;
    chk(tag, rd_a_data, e);
    chk({tag, " portB"}, rd_b_data, e);
  endtask

  task automatic t_reset;
    rd("R11 user R0", USR, 4'd0, 32'h0);
    rd("R11 fiq R8", FIQ, 4'd8, 32'h0);
    rd("R11 svc R13", SVC, 4'd13, 32'h0);
    rd("R11 R15", USR, 4'd15, 32'h0C00_0000);
    chk("R11 fetch", {6'd0, fetch_addr}, 32'h0);
  endtask

  task automatic t_fiq;
    for (int i = 0; i < 15; i++) wr(USR, 4'(i), 32'h1000_0000 + 32'(i));
    wr(FIQ, 4'd8, 32'hF1F0_0008);
    wr(FIQ, 4'd14, 32'hF1F0_000E);
    wr(FIQ, 4'd3, 32'hF1F0_0003);
    rd("R1 fiq R8", FIQ, 4'd8, 32'hF1F0_0008);
    rd("R1 fiq R14", FIQ, 4'd14, 32'hF1F0_000E);
    rd("R1 user R8 untouched", USR, 4'd8, 32'h1000_0008);
    rd("R1 user R14 untouched", USR, 4'd14, 32'h1000_000E);
    rd("R1 fiq R12 private", FIQ, 4'd12, 32'h0);
    rd("R3 user sees fiq R3", USR, 4'd3, 32'hF1F0_0003);
    rd("R3 fiq sees user R7", FIQ, 4'd7, 32'h1000_0007);
  endtask

  task automatic t_svc_irq;
    wr(SVC, 4'd13, 32'h5555_000D);
    wr(IRQ, 4'd13, 32'h9999_000D);
    wr(SVC, 4'd12, 32'h5555_000C);
    rd("R12 svc R13", SVC, 4'd13, 32'h5555_000D);
    rd("R12 irq R13", IRQ, 4'd13, 32'h9999_000D);
    rd("R2 user R13", USR, 4'd13, 32'h1000_000D);
    rd("R2 user sees svc R12", USR, 4'd12, 32'h5555_000C);
    rd("R2 irq R8 shared", IRQ, 4'd8, 32'h1000_0008);
    rd("R2 fiq R12 separate", FIQ, 4'd12, 32'h0);
  endtask

  task automatic t_r15;
    wr(SVC, 4'd15, {4'hA, 2'b01, 24'h123456, 2'b10});
    rd("R6 svc R15", SVC, 4'd15, {4'hA, 2'b01, 24'h123456, 2'b11});
    chk("R5 fetch", {6'd0, fetch_addr}, {6'd0, 24'h123456, 2'b00});
    wr(USR, 4'd15, {4'h5, 2'b10, 24'h000ABC, 2'b11});
    rd("R7 user R15", USR, 4'd15, {4'h5, 2'b01, 24'h000ABC, 2'b00});
    rd("R4 R15 in fiq", FIQ, 4'd15, {4'h5, 2'b01, 24'h000ABC, 2'b01});
  endtask

  task automatic t_paths;
    @(negedge clk);
    mode_i = SVC; wr_en = 1; wr_addr = 4'd15; wr_data = {4'h3, 2'b10, 24'h777777, 2'b00};
    pc_we = 1; pc_next = 24'h00BEEF;
    @(negedge clk);
    wr_en = 0; pc_we = 0;
    rd("R8 pc wins, flags and masks from port", SVC, 4'd15, {4'h3, 2'b10, 24'h00BEEF, 2'b11});
    @(negedge clk);
    flags_we = 1; flags_next = 4'h9;
    @(negedge clk);
    flags_we = 0;
    rd("R8 flags path", USR, 4'd15, {4'h9, 2'b10, 24'h00BEEF, 2'b00});
  endtask

  task automatic t_link;
    @(negedge clk);
    mode_i = SVC; wr_en = 1; wr_addr = 4'd14; wr_data = 32'hDEAD_0000;
    link_we = 1; link_mode = SVC;
    @(negedge clk);
    wr_en = 0; link_we = 0;
    rd("R9 link beats port", SVC, 4'd14, {4'h9, 2'b10, 24'h00BEEF, 2'b11});
    @(negedge clk);
    mode_i = USR; link_we = 1; link_mode = IRQ;
    @(negedge clk);
    link_we = 0;
    rd("R9 link into irq R14", IRQ, 4'd14, {4'h9, 2'b10, 24'h00BEEF, 2'b00});
    rd("R9 user R14 kept", USR, 4'd14, 32'h1000_000E);
  endtask

  task automatic t_rdw;
    @(negedge clk);
    mode_i = USR; wr_en = 1; wr_addr = 4'd5; wr_data = 32'hC0DE_0005; rd_a_addr = 4'd5;
    #1;
    chk("R10 old value before edge", rd_a_data, 32'h1000_0005);
    @(posedge clk);
    #1;
    chk("R10 new value after edge", rd_a_data, 32'hC0DE_0005);
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fiq();
    t_svc_irq();
    t_r15();
    t_paths();
    t_link();
    t_rdw();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule